// File: doc/BRIEF.md
# Keyed Telecommand Receiver Control Registers

This block is the register front end of a telecommand receiver. It sits on a simple 32-bit register bus with separate write and read strobes. Reads are registered, so the data comes back one cycle later with a valid flag. The block holds the operating-mode bits, the receiver enable, an interrupt mask and a set of sticky event flags. It also produces two self-clearing strobes: one resets the receiver and one soft-resets the whole core.

The global reset, global control and receiver control registers are protected against stray writes. A write to any of them is accepted only when the top byte of the write data carries the key value 0x55. The mask and event-clear registers take plain writes.

Receiver events arrive as single-cycle pulses and set sticky pending flags. Software can read the flags without side effects, or read them through a status address that clears them in the same access. It can also clear chosen flags by writing ones. The interrupt line is registered. It is high while any pending flag is also enabled in the mask.

Top module: `tc_keyed_regs`

## Requirements
- R1: After the reset input is released, every output is low, and reads of the control (0x04), receiver control (0x20), pending (0x6C) and mask (0x70) registers return zero.
- R2: A write to 0x04 with bits 31:24 equal to 0x55 loads bit 10 to modeRand, bit 11 to modeNrzm and bit 12 to modePps. A read of 0x04 returns these bits in the same positions. A write to 0x04 without the key changes nothing.
- R3: A keyed write to 0x20 loads bit 0 into rxEnable, which reads back at bit 0 of 0x20. An unkeyed write to 0x20 changes nothing.
- R4: A keyed write to 0x20 with bit 3 set drives rxResetPulse high for exactly the one cycle after the write. Bit 3 of 0x20 always reads as zero.
- R5: A keyed write to 0x00 with bit 0 set drives coreResetPulse high for one cycle and returns all other state to zero: modes, enable, mask, pending flags and interrupt. An unkeyed write to 0x00 has no effect. Bit 0 of 0x00 reads as zero.
- R6: A one-cycle pulse on evtPulse[i] sets pending bit i, which stays set until cleared. A read of 0x6C returns the pending bits without changing them.
- R7: A read of 0x68 returns the pending bits and clears them.
- R8: A write to 0x74 clears exactly the pending bits written as one and leaves the others set.
- R9: An event pulse arriving in the same cycle as a clear (by a write to 0x74 or a read of 0x68) leaves its pending bit set.
- R10: The mask register at 0x70 loads from a plain write and reads back. irq is high one cycle after any pending bit is set in a position where the mask is also set, and it drops one cycle after no such bit remains.
- R11: Every read returns data with rdValid high in the cycle after rdEn. Reads of unmapped addresses return zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data; bits 31:24 carry the key |
| rdData | output | 32 | Read data, valid when rdValid is high |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| evtPulse | input | NUM_EVT | Single-cycle receiver event pulses |
| irq | output | 1 | Registered interrupt request |
| modeRand | output | 1 | De-randomiser enable |
| modeNrzm | output | 1 | NRZ-M decoding enable |
| modePps | output | 1 | Pulse-per-second style mode enable |
| rxEnable | output | 1 | Receiver enable |
| rxResetPulse | output | 1 | One-cycle receiver reset strobe |
| coreResetPulse | output | 1 | One-cycle whole-core soft reset strobe |

## Verification
The bench builds the block with its default parameters: an 8-bit address, six event sources and key byte 0x55. With six sources, the test can mask some events and leave others unmasked, and it can clear the set with a mixed write-one pattern. These choices reach the boundary between masked and unmasked events and the case of a partial clear. An 8-bit address also brings an unmapped offset within reach, so the bench checks that such accesses are ignored. The same-cycle collisions between an event and both kinds of clear are driven explicitly, and so is a soft reset taken while flags, mask and modes are all non-zero.

// File: rtl/tc_keyed_regs_pkg.sv
package tc_keyed_regs_pkg;

  // Register offsets (software decodes these)
  localparam logic [7:0] OFF_GRST  = 8'h00;
  localparam logic [7:0] OFF_GCTL  = 8'h04;
  localparam logic [7:0] OFF_RXC   = 8'h20;
  localparam logic [7:0] OFF_STAT  = 8'h68;
  localparam logic [7:0] OFF_PEND  = 8'h6C;
  localparam logic [7:0] OFF_MASK  = 8'h70;
  localparam logic [7:0] OFF_CLR   = 8'h74;

  // Field positions
  localparam int SRST_BIT  = 0;
  localparam int RAND_BIT  = 10;
  localparam int NRZM_BIT  = 11;
  localparam int PPS_BIT   = 12;
  localparam int RXEN_BIT  = 0;
  localparam int RXRST_BIT = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GCTL,
    SEL_RXC,
    SEL_PEND,
    SEL_MASK
  } rdSel_e;

  typedef struct packed {
    logic   softRst;
    logic   gctlWr;
    logic   rxcWr;
    logic   maskWr;
    logic   clrWr;
    logic   statRd;
    logic   rdReq;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/tc_keyed_regs_ctrl.sv
module tc_keyed_regs_ctrl
  import tc_keyed_regs_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] KEY_BYTE = 8'h55
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        keyByte,
  input  logic              srstBit,
  output strobes_t          st
);

  logic keyOk;
  logic hitGrst, hitGctl, hitRxc, hitStat, hitPend, hitMask, hitClr;

  assign keyOk   = (keyByte == KEY_BYTE);
  assign hitGrst = (addr == ADDR_W'(OFF_GRST));
  assign hitGctl = (addr == ADDR_W'(OFF_GCTL));
  assign hitRxc  = (addr == ADDR_W'(OFF_RXC));
  assign hitStat = (addr == ADDR_W'(OFF_STAT));
  assign hitPend = (addr == ADDR_W'(OFF_PEND));
  assign hitMask = (addr == ADDR_W'(OFF_MASK));
  assign hitClr  = (addr == ADDR_W'(OFF_CLR));

  always_comb begin
    st         = '0;
    st.softRst = wrEn && hitGrst && keyOk && srstBit;
    st.gctlWr  = wrEn && hitGctl && keyOk;
    st.rxcWr   = wrEn && hitRxc && keyOk;
    st.maskWr  = wrEn && hitMask;
    st.clrWr   = wrEn && hitClr;
    st.statRd  = rdEn && hitStat;
    st.rdReq   = rdEn;
    if (hitGctl)                st.rdSel = SEL_GCTL;
    else if (hitRxc)            st.rdSel = SEL_RXC;
    else if (hitStat || hitPend) st.rdSel = SEL_PEND;
    else if (hitMask)           st.rdSel = SEL_MASK;
    else                        st.rdSel = SEL_NONE;
  end

endmodule

// File: rtl/tc_keyed_regs_dp.sv
module tc_keyed_regs_dp
  import tc_keyed_regs_pkg::*;
#(
  parameter int NUM_EVT = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           st,
  input  logic [2:0]         modeIn,
  input  logic               rxEnIn,
  input  logic               rxRstIn,
  input  logic [NUM_EVT-1:0] bitsIn,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic [31:0]        rdData,
  output logic               rdValid,
  output logic               irq,
  output logic [2:0]         modeQ,
  output logic               rxEnQ,
  output logic               rxRstQ,
  output logic               softRstQ
);

  logic [NUM_EVT-1:0] pendQ, pendNext, maskQ, clrBits;
  logic [31:0]        rdMux;

  assign clrBits = (st.clrWr ? bitsIn : '0) | (st.statRd ? '1 : '0);

  // One sticky cell per event source; a set pulse wins over a clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : gPend
    assign pendNext[i] = evtPulse[i] | (pendQ[i] & ~clrBits[i]);
  end

  always_comb begin
    rdMux = '0;
    case (st.rdSel)
      SEL_GCTL: begin
        rdMux[RAND_BIT] = modeQ[0];
        rdMux[NRZM_BIT] = modeQ[1];
        rdMux[PPS_BIT]  = modeQ[2];
      end
      SEL_RXC:  rdMux[RXEN_BIT] = rxEnQ;
      SEL_PEND: rdMux = 32'(pendQ);
      SEL_MASK: rdMux = 32'(maskQ);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ    <= '0;
      maskQ    <= '0;
      modeQ    <= '0;
      rxEnQ    <= 1'b0;
      rxRstQ   <= 1'b0;
      softRstQ <= 1'b0;
      irq      <= 1'b0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else if (st.softRst) begin
      pendQ    <= '0;
      maskQ    <= '0;
      modeQ    <= '0;
      rxEnQ    <= 1'b0;
      rxRstQ   <= 1'b0;
      softRstQ <= 1'b1;
      irq      <= 1'b0;
      rdData   <= '0;
      rdValid  <= st.rdReq;
    end else begin
      softRstQ <= 1'b0;
      rxRstQ   <= st.rxcWr && rxRstIn;
      if (st.gctlWr) modeQ <= modeIn;
      if (st.rxcWr)  rxEnQ <= rxEnIn;
      if (st.maskWr) maskQ <= bitsIn;
      pendQ    <= pendNext;
      irq      <= |(pendQ & maskQ);
      rdValid  <= st.rdReq;
      rdData   <= st.rdReq ? rdMux : '0;
    end
  end

endmodule

// File: rtl/tc_keyed_regs.sv
module tc_keyed_regs
  import tc_keyed_regs_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         NUM_EVT  = 6,
  parameter logic [7:0] KEY_BYTE = 8'h55
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdData,
  output logic               rdValid,
  input  logic [NUM_EVT-1:0] evtPulse,
  output logic               irq,
  output logic               modeRand,
  output logic               modeNrzm,
  output logic               modePps,
  output logic               rxEnable,
  output logic               rxResetPulse,
  output logic               coreResetPulse
);

  strobes_t   st;
  logic [2:0] modeQ;

  tc_keyed_regs_ctrl #(.ADDR_W(ADDR_W), .KEY_BYTE(KEY_BYTE)) uCtrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .keyByte (wdata[31:24]),
    .srstBit (wdata[SRST_BIT]),
    .st      (st)
  );

  tc_keyed_regs_dp #(.NUM_EVT(NUM_EVT)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .modeIn   ({wdata[PPS_BIT], wdata[NRZM_BIT], wdata[RAND_BIT]}),
    .rxEnIn   (wdata[RXEN_BIT]),
    .rxRstIn  (wdata[RXRST_BIT]),
    .bitsIn   (wdata[NUM_EVT-1:0]),
    .evtPulse (evtPulse),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .irq      (irq),
    .modeQ    (modeQ),
    .rxEnQ    (rxEnable),
    .rxRstQ   (rxResetPulse),
    .softRstQ (coreResetPulse)
  );

  assign modeRand = modeQ[0];
  assign modeNrzm = modeQ[1];
  assign modePps  = modeQ[2];

endmodule

// File: rtl/tc_keyed_regs_chk.sv
module tc_keyed_regs_chk
  import tc_keyed_regs_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter int         NUM_EVT  = 6,
  parameter logic [7:0] KEY_BYTE = 8'h55
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [31:0]        wdata,
  input logic [31:0]        rdData,
  input logic               rdValid,
  input logic [NUM_EVT-1:0] evtPulse,
  input logic               irq,
  input logic               modeRand,
  input logic               modeNrzm,
  input logic               modePps,
  input logic               rxEnable,
  input logic               rxResetPulse,
  input logic               coreResetPulse
);

  // R2
  unkeyed_gctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(OFF_GCTL) && wdata[31:24] != KEY_BYTE)
      |=> $stable({modeRand, modeNrzm, modePps}));

  // R4
  rx_reset_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxResetPulse |-> $past(wrEn && addr == ADDR_W'(OFF_RXC) &&
                           wdata[31:24] == KEY_BYTE && wdata[RXRST_BIT]));

  // R5
  core_reset_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreResetPulse |-> $past(wrEn && addr == ADDR_W'(OFF_GRST) &&
                             wdata[31:24] == KEY_BYTE && wdata[SRST_BIT]));

  // R5
  core_reset_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreResetPulse |-> !(irq || rxEnable || modeRand || modeNrzm || modePps));

  // R11
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  // R11
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

endmodule

bind tc_keyed_regs tc_keyed_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .KEY_BYTE(KEY_BYTE)
) uChk (.*);

// File: tb/sim_tc_keyed_regs.sv
`timescale 1ns/1ps
module sim_tc_keyed_regs;

  localparam int ADDR_W  = 8;
  localparam int NUM_EVT = 6;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               wrEn = 1'b0;
  logic               rdEn = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [31:0]        wdata = '0;
  logic [31:0]        rdData;
  logic               rdValid;
  logic [NUM_EVT-1:0] evtPulse = '0;
  logic               irq, modeRand, modeNrzm, modePps;
  logic               rxEnable, rxResetPulse, coreResetPulse;

  int checks = 0;
  int fails  = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  tc_keyed_regs #(.ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .KEY_BYTE(8'h55)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdData(rdData), .rdValid(rdValid), .evtPulse(evtPulse),
    .irq(irq), .modeRand(modeRand), .modeNrzm(modeNrzm), .modePps(modePps),
    .rxEnable(rxEnable), .rxResetPulse(rxResetPulse),
    .coreResetPulse(coreResetPulse)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0; wdata = '0;
  endtask

  // Driver side of the scoreboard
  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_EVT-1:0] e);
    @(negedge clk);
    evtPulse = e;
    @(negedge clk);
    evtPulse = '0;
  endtask

  // Monitor side of the scoreboard
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11 unexpected rdValid", rdData, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(rdData == e, t, rdData, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({irq, modeRand, modeNrzm, modePps, rxEnable, rxResetPulse, coreResetPulse, rdValid} == 8'h0,
          "R1 outputs after reset", {24'h0, irq, modeRand, modeNrzm, modePps, rxEnable,
          rxResetPulse, coreResetPulse, rdValid}, 32'h0);
    busRead(8'h04, 32'h0, "R1 gctl reset");
    busRead(8'h20, 32'h0, "R1 rxc reset");
    busRead(8'h6C, 32'h0, "R1 pend reset");
    busRead(8'h70, 32'h0, "R1 mask reset");

    // R2 keyed mode bits
    busWrite(8'h04, 32'h0000_1C00);
    check({modeRand, modeNrzm, modePps} == 3'b000, "R2 unkeyed gctl ignored",
          {29'h0, modePps, modeNrzm, modeRand}, 32'h0);
    busWrite(8'h04, 32'h5500_1400);
    check({modePps, modeNrzm, modeRand} == 3'b101, "R2 keyed gctl",
          {29'h0, modePps, modeNrzm, modeRand}, 32'h5);
    busRead(8'h04, 32'h0000_1400, "R2 gctl readback");

    // R3 receiver enable
    busWrite(8'h20, 32'h0000_0001);
    check(rxEnable == 1'b0, "R3 unkeyed rxc ignored", {31'h0, rxEnable}, 32'h0);
    busWrite(8'h20, 32'h5500_0001);
    check(rxEnable == 1'b1, "R3 keyed enable", {31'h0, rxEnable}, 32'h1);
    busRead(8'h20, 32'h1, "R3 rxc readback");

    // R4 receiver reset strobe
    busWrite(8'h20, 32'h5500_0009);
    check(rxResetPulse == 1'b1, "R4 rx reset high", {31'h0, rxResetPulse}, 32'h1);
    @(negedge clk);
    check(rxResetPulse == 1'b0, "R4 rx reset self-clears", {31'h0, rxResetPulse}, 32'h0);
    busRead(8'h20, 32'h1, "R4 reset bit reads zero");

    // R6 sticky flags, R7 clear on read
    pulse(6'b000101);
    busRead(8'h6C, 32'h5, "R6 pend after events");
    busRead(8'h6C, 32'h5, "R6 pend read non-destructive");
    busRead(8'h68, 32'h5, "R7 status read value");
    busRead(8'h6C, 32'h0, "R7 status read cleared");

    // R8 write-one-to-clear
    pulse(6'b110010);
    busWrite(8'h74, 32'h0000_0010);
    busRead(8'h6C, 32'h22, "R8 partial clear");

    // R9 set wins over write clear
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h74; wdata = 32'h10; evtPulse = 6'h10;
    @(negedge clk);
    wrEn = 1'b0; wdata = '0; evtPulse = '0;
    busRead(8'h6C, 32'h32, "R9 set wins over clear write");
    // R9 set wins over clear-on-read
    @(negedge clk);
    rdEn = 1'b1; addr = 8'h68; evtPulse = 6'h01;
    expQ.push_back(32'h32); tagQ.push_back("R9 status read during event");
    @(negedge clk);
    rdEn = 1'b0; evtPulse = '0;
    busRead(8'h6C, 32'h01, "R9 event kept after status read");

    // R10 masked interrupt
    check(irq == 1'b0, "R10 irq low while masked", {31'h0, irq}, 32'h0);
    busWrite(8'h70, 32'h0000_0001);
    @(negedge clk);
    check(irq == 1'b1, "R10 irq on unmasked pending", {31'h0, irq}, 32'h1);
    busRead(8'h70, 32'h1, "R10 mask readback");
    busWrite(8'h74, 32'h0000_0001);
    @(negedge clk);
    check(irq == 1'b0, "R10 irq drops after clear", {31'h0, irq}, 32'h0);
    busWrite(8'h70, 32'h0000_0004);
    pulse(6'b000010);
    @(negedge clk);
    check(irq == 1'b0, "R10 masked event no irq", {31'h0, irq}, 32'h0);
    pulse(6'b000100);
    @(negedge clk);
    check(irq == 1'b1, "R10 unmasked event irq", {31'h0, irq}, 32'h1);

    // R11 unmapped access
    busWrite(8'h40, 32'h55FF_FFFF);
    busRead(8'h40, 32'h0, "R11 unmapped reads zero");
    busRead(8'h00, 32'h0, "R5 reset reg reads zero");
    busRead(8'h04, 32'h0000_1400, "R11 unmapped write left gctl");

    // R5 soft reset
    busWrite(8'h00, 32'h0000_0001);
    check(coreResetPulse == 1'b0, "R5 unkeyed soft reset ignored", {31'h0, coreResetPulse}, 32'h0);
    busWrite(8'h00, 32'h5500_0001);
    check(coreResetPulse == 1'b1, "R5 soft reset strobe", {31'h0, coreResetPulse}, 32'h1);
    check({irq, rxEnable, modeRand, modeNrzm, modePps} == 5'h0, "R5 state cleared",
          {27'h0, irq, rxEnable, modeRand, modeNrzm, modePps}, 32'h0);
    @(negedge clk);
    check(coreResetPulse == 1'b0, "R5 soft reset self-clears", {31'h0, coreResetPulse}, 32'h0);
    busRead(8'h70, 32'h0, "R5 mask cleared");
    busRead(8'h6C, 32'h0, "R5 pend cleared");
    busRead(8'h04, 32'h0, "R5 gctl cleared");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R11 all reads answered", expQ.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule